// File: doc/BRIEF.md
# Alarm Status Collector with Change Interrupt

This block gathers a set of live alarm levels from a receive path (for example pointer loss, path alarm indication, remote defect and far-end receive failure) into a status register that software can read. It also keeps a sticky flag that records a wrap of the far-end block error counter. A single interrupt line tells software that something changed. The alarm status bits are live: each follows its alarm level and is not cleared by a read.

The interrupt fires on both a rise and a fall of any alarm status bit, and also on a counter wrap. It stays active until software reads any status register. A read that happens in the same cycle as a new event does not lose that event. The alarm detection logic, the error counter and any bus protocol beyond a one-cycle read strobe with an address sit outside this block.

Top module: `alm_irq_top`

## Requirements
- R1: A synchronous active-high reset clears every alarm status bit, the sticky wrap flag, the interrupt and the read data register.
- R2: Address 0 reads the alarm status register. Bit i holds alarm level i as it was sampled on the clock edge before the read. Unused upper bits read as 0.
- R3: A low-to-high change of any alarm level makes `irq` high one clock edge later.
- R4: A high-to-low change of any alarm level makes `irq` high one clock edge later.
- R5: Reading address 0 leaves the alarm status bits unchanged. A repeated read returns the same value while the levels are steady.
- R6: A read of address 0 or address 1 with no new event in the same cycle drives `irq` low at the next edge.
- R7: A one-cycle `wrap_pulse` sets the sticky wrap flag (address 1, bit 0) and makes `irq` high one edge later.
- R8: Reading address 1 returns the sticky flag and then clears it. If a wrap pulse arrives in the same cycle as the read, the flag stays set.
- R9: When an alarm change or a wrap pulse falls in the same cycle as a status read, `irq` stays high.
- R10: A read of address 2 or 3 returns 0 and leaves `irq` unchanged.
- R11: With no event and no status read, `irq` keeps its value.
- R12: Read data is registered. It appears one edge after the strobe and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (hardware or software) |
| alarm_lvl | input | NUM_ALM | Live alarm levels, one bit per alarm |
| wrap_pulse | input | 1 | One-cycle pulse when the far-end block error counter rolls over |
| rd_en | input | 1 | Read strobe, one cycle |
| rd_addr | input | 2 | Register address for the read |
| rd_data | output | DATA_W | Registered read data |
| irq | output | 1 | Interrupt, active high |

## Verification
Single alarm bits are raised and dropped on their own. This shows whether rising and falling edges each raise the interrupt, and whether a read clears it. Reads timed to coincide with an alarm change or a wrap pulse show whether the design lets the event win over the acknowledge. Reads to the unused addresses show whether the decoder leaves the interrupt alone. A long run follows with sparse random alarm toggles, wrap pulses and reads to all four addresses, mixed with a reset in mid-run. Its results are compared cycle by cycle against a reference model in the bench. This run catches wrong edge polarity, stale read data and a sticky flag that clears too early or too late.

// File: rtl/alm_pkg.sv
package alm_pkg;

    localparam int ALM_ADDR_W  = 2;
    localparam int ALM_DEF_NUM = 4;
    localparam int ALM_DEF_DW  = 8;

    typedef enum logic [ALM_ADDR_W-1:0] {
        REG_ALARM  = 2'd0,
        REG_WRAP   = 2'd1,
        REG_RSVD_A = 2'd2,
        REG_RSVD_B = 2'd3
    } alm_reg_e;

    typedef struct packed {
        logic     en;
        alm_reg_e sel;
    } alm_rd_req_t;

    typedef struct packed {
        logic alarm_chg;
        logic wrap_set;
    } alm_evt_t;

    function automatic logic reg_is_status(alm_reg_e sel);
        return (sel == REG_ALARM) || (sel == REG_WRAP);
    endfunction

    function automatic logic evt_any(alm_evt_t e);
        return e.alarm_chg | e.wrap_set;
    endfunction

endpackage

// File: rtl/alm_level_track.sv
module alm_level_track #(
    parameter int NUM_ALM = alm_pkg::ALM_DEF_NUM
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_ALM-1:0] lvl_i,
    output logic [NUM_ALM-1:0] stat_o,
    output logic               chg_o
);
    logic [NUM_ALM-1:0] stat_q;
    logic [NUM_ALM-1:0] diff;

    // Each bit is registered; a change is found by comparing the level with its
    // value one clock earlier (R2, R3, R4).
    for (genvar i = 0; i < NUM_ALM; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) stat_q[i] <= 1'b0;
            else     stat_q[i] <= lvl_i[i];
        end
        assign diff[i] = lvl_i[i] ^ stat_q[i];
    end

    assign stat_o = stat_q;
    assign chg_o  = |diff;
endmodule

// File: rtl/alm_wrap_sticky.sv
module alm_wrap_sticky (
    input  logic clk,
    input  logic rst,
    input  logic wrap_i,
    input  logic clr_i,
    output logic flag_o
);
    logic flag_q;

    // A set beats a clear arriving in the same cycle (R8).
    always_ff @(posedge clk) begin
        if (rst)         flag_q <= 1'b0;
        else if (wrap_i) flag_q <= 1'b1;
        else if (clr_i)  flag_q <= 1'b0;
    end

    assign flag_o = flag_q;
endmodule

// File: rtl/alm_irq_gen.sv
module alm_irq_gen (
    input  logic            clk,
    input  logic            rst,
    input  alm_pkg::alm_evt_t evt_i,
    input  logic            ack_i,
    output logic            irq_o
);
    logic irq_q;

    // A new event wins over an acknowledge in the same cycle (R9).
    always_ff @(posedge clk) begin
        if (rst)                         irq_q <= 1'b0;
        else if (alm_pkg::evt_any(evt_i)) irq_q <= 1'b1;
        else if (ack_i)                  irq_q <= 1'b0;
    end

    assign irq_o = irq_q;
endmodule

// File: rtl/alm_rd_port.sv
module alm_rd_port #(
    parameter int NUM_ALM = alm_pkg::ALM_DEF_NUM,
    parameter int DATA_W  = alm_pkg::ALM_DEF_DW
) (
    input  logic                clk,
    input  logic                rst,
    input  alm_pkg::alm_rd_req_t req_i,
    input  logic [NUM_ALM-1:0]  stat_i,
    input  logic                flag_i,
    output logic [DATA_W-1:0]   data_o,
    output logic                ack_o,
    output logic                flag_clr_o
);
    import alm_pkg::*;

    logic [DATA_W-1:0] mux_d;
    logic [DATA_W-1:0] data_q;

    always_comb begin
        mux_d = '0;
        unique case (req_i.sel)
            REG_ALARM: for (int i = 0; i < NUM_ALM; i++) mux_d[i] = stat_i[i];
            REG_WRAP:  mux_d[0] = flag_i;
            default:   mux_d = '0;
        endcase
    end

    // Registered read data, held between strobes (R12, R10).
    always_ff @(posedge clk) begin
        if (rst)           data_q <= '0;
        else if (req_i.en) data_q <= mux_d;
    end

    assign data_o     = data_q;
    assign ack_o      = req_i.en && reg_is_status(req_i.sel);
    assign flag_clr_o = req_i.en && (req_i.sel == REG_WRAP);
endmodule

// File: rtl/alm_irq_top.sv
module alm_irq_top #(
    parameter int NUM_ALM = alm_pkg::ALM_DEF_NUM,
    parameter int DATA_W  = alm_pkg::ALM_DEF_DW
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [NUM_ALM-1:0]            alarm_lvl,
    input  logic                          wrap_pulse,
    input  logic                          rd_en,
    input  logic [alm_pkg::ALM_ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0]             rd_data,
    output logic                          irq
);
    import alm_pkg::*;

    localparam int PAD_W = DATA_W - NUM_ALM;

    logic [NUM_ALM-1:0] stat_q;
    logic               alarm_chg;
    logic               wrap_flag;
    logic               flag_clr;
    logic               rd_ack;
    alm_rd_req_t        rd_req;
    alm_evt_t           evt;

    if (PAD_W < 0) begin : g_bad_width
        initial $error("DATA_W must be at least NUM_ALM");
    end

    assign rd_req.en  = rd_en;
    assign rd_req.sel = alm_reg_e'(rd_addr);

    alm_level_track #(.NUM_ALM(NUM_ALM)) u_track (
        .clk    (clk),
        .rst    (rst),
        .lvl_i  (alarm_lvl),
        .stat_o (stat_q),
        .chg_o  (alarm_chg)
    );

    alm_wrap_sticky u_sticky (
        .clk    (clk),
        .rst    (rst),
        .wrap_i (wrap_pulse),
        .clr_i  (flag_clr),
        .flag_o (wrap_flag)
    );

    assign evt.alarm_chg = alarm_chg;
    assign evt.wrap_set  = wrap_pulse;

    alm_irq_gen u_irq (
        .clk   (clk),
        .rst   (rst),
        .evt_i (evt),
        .ack_i (rd_ack),
        .irq_o (irq)
    );

    alm_rd_port #(.NUM_ALM(NUM_ALM), .DATA_W(DATA_W)) u_rd (
        .clk        (clk),
        .rst        (rst),
        .req_i      (rd_req),
        .stat_i     (stat_q),
        .flag_i     (wrap_flag),
        .data_o     (rd_data),
        .ack_o      (rd_ack),
        .flag_clr_o (flag_clr)
    );
endmodule

// File: rtl/alm_irq_chk.sv
module alm_irq_chk #(
    parameter int NUM_ALM = alm_pkg::ALM_DEF_NUM,
    parameter int DATA_W  = alm_pkg::ALM_DEF_DW
) (
    input logic                          clk,
    input logic                          rst,
    input logic [NUM_ALM-1:0]            alarm_lvl,
    input logic                          wrap_pulse,
    input logic                          rd_en,
    input logic [alm_pkg::ALM_ADDR_W-1:0] rd_addr,
    input logic [DATA_W-1:0]             rd_data,
    input logic                          irq,
    input logic [NUM_ALM-1:0]            stat_q,
    input logic                          wrap_flag
);
    logic rd_status;
    logic any_evt;
    assign rd_status = rd_en && (rd_addr < 2'd2);
    assign any_evt   = (alarm_lvl != stat_q) || wrap_pulse;

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (!irq && rd_data == '0 && stat_q == '0 && !wrap_flag)); // R1
    AST_STAT_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> stat_q == $past(alarm_lvl)); // R2
    AST_CHANGE_IRQ: assert property (@(posedge clk) disable iff (rst)
        (alarm_lvl != stat_q) |=> irq); // R3
    AST_WRAP_SET: assert property (@(posedge clk) disable iff (rst)
        wrap_pulse |=> (wrap_flag && irq)); // R7
    AST_ACK_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (rd_status && !any_evt) |=> !irq); // R6
    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (irq && !rd_status) |=> irq); // R11
    AST_NO_CAUSE: assert property (@(posedge clk) disable iff (rst)
        (!irq && !any_evt) |=> !irq); // R11
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rd_addr >= 2'd2) |=> rd_data == '0); // R10
    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!rd_en && !$past(rst)) |=> $stable(rd_data)); // R12
endmodule

bind alm_irq_top alm_irq_chk #(.NUM_ALM(NUM_ALM), .DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .alarm_lvl  (alarm_lvl),
    .wrap_pulse (wrap_pulse),
    .rd_en      (rd_en),
    .rd_addr    (rd_addr),
    .rd_data    (rd_data),
    .irq        (irq),
    .stat_q     (stat_q),
    .wrap_flag  (wrap_flag)
);

// File: tb/sim_alm_irq_top.sv
module sim_alm_irq_top;
    localparam int N  = 4;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [N-1:0]  alarm_lvl = '0;
    logic          wrap_pulse = 1'b0;
    logic          rd_en = 1'b0;
    logic [1:0]    rd_addr = '0;
    logic [DW-1:0] rd_data;
    logic          irq;

    int total = 0;
    int bad   = 0;

    // reference model state
    logic [N-1:0]  m_stat = '0;
    logic          m_flag = 1'b0;
    logic          m_irq  = 1'b0;
    logic [DW-1:0] m_data = '0;

    always #5 clk = ~clk;

    alm_irq_top #(.NUM_ALM(N), .DATA_W(DW)) u0 (
        .clk(clk), .rst(rst), .alarm_lvl(alarm_lvl), .wrap_pulse(wrap_pulse),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
    );

    function automatic logic [DW-1:0] exp_read(logic [1:0] a, logic [N-1:0] s, logic f);
        logic [DW-1:0] d = '0;
        if (a == 2'd0) d[N-1:0] = s;
        else if (a == 2'd1) d[0] = f;
        return d;
    endfunction

    function automatic logic exp_irq(logic cur, logic ev, logic ack);
        if (ev) return 1'b1;
        if (ack) return 1'b0;
        return cur;
    endfunction

    task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_step();
        logic ev, ack;
        if (rst) begin
            m_stat = '0; m_flag = 1'b0; m_irq = 1'b0; m_data = '0;
        end else begin
            ev  = (alarm_lvl != m_stat) || wrap_pulse;
            ack = rd_en && (rd_addr < 2'd2);
            if (rd_en) m_data = exp_read(rd_addr, m_stat, m_flag);
            m_irq = exp_irq(m_irq, ev, ack);
            if (wrap_pulse) m_flag = 1'b1;
            else if (rd_en && rd_addr == 2'd1) m_flag = 1'b0;
            m_stat = alarm_lvl;
        end
    endtask

    // one cycle: drive at negedge, model at posedge, compare at next negedge
    task automatic step(logic [N-1:0] lvl, logic wp, logic re, logic [1:0] ad, string tag);
        alarm_lvl = lvl; wrap_pulse = wp; rd_en = re; rd_addr = ad;
        @(posedge clk);
        model_step();
        @(negedge clk);
        check({tag, " irq"}, {{(DW-1){1'b0}}, irq}, {{(DW-1){1'b0}}, m_irq});
        check({tag, " rd_data"}, rd_data, m_data);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        step('0, 1'b0, 1'b0, 2'd0, "R1");
        step('0, 1'b0, 1'b0, 2'd0, "R1");
        rst = 1'b0;
    endtask

    initial begin
        int unsigned seed;
        logic [N-1:0] lvl;
        seed = $urandom(32'd2024);
        @(negedge clk);
        do_reset();
        check("R1 irq after reset", {{(DW-1){1'b0}}, irq}, '0);
        step('0, 0, 1, 2'd0, "R1");            // alarm reg reads 0
        step('0, 0, 1, 2'd1, "R1");            // wrap flag reads 0

        // R3: rising edge of bit 2
        step(4'b0100, 0, 0, 2'd0, "R3");
        check("R3 irq high", {{(DW-1){1'b0}}, irq}, 8'd1);
        step(4'b0100, 0, 0, 2'd0, "R11");
        step(4'b0100, 0, 1, 2'd0, "R6");       // R2 reads 0x04, irq drops
        check("R2 read alarm", rd_data, 8'h04);
        check("R6 irq cleared", {{(DW-1){1'b0}}, irq}, 8'd0);
        step(4'b0100, 0, 1, 2'd0, "R5");
        check("R5 reread", rd_data, 8'h04);

        // R4: falling edge
        step(4'b0000, 0, 0, 2'd0, "R4");
        check("R4 irq high", {{(DW-1){1'b0}}, irq}, 8'd1);

        // R10: reserved address keeps irq and reads zero
        step(4'b0000, 0, 1, 2'd3, "R10");
        check("R10 irq kept", {{(DW-1){1'b0}}, irq}, 8'd1);
        check("R10 data zero", rd_data, 8'h00);
        step(4'b0000, 0, 1, 2'd2, "R10");
        step(4'b0000, 0, 0, 2'd0, "R12");
        check("R12 data held", rd_data, 8'h00);
        step(4'b0000, 0, 1, 2'd0, "R6");

        // R7, R8: wrap sticky
        step(4'b0000, 1, 0, 2'd0, "R7");
        check("R7 irq", {{(DW-1){1'b0}}, irq}, 8'd1);
        step(4'b0000, 0, 1, 2'd1, "R8");
        check("R8 read flag", rd_data, 8'h01);
        step(4'b0000, 0, 1, 2'd1, "R8");
        check("R8 flag cleared", rd_data, 8'h00);

        // R8: pulse coincident with read keeps flag
        step(4'b0000, 1, 0, 2'd0, "R7");
        step(4'b0000, 1, 1, 2'd1, "R9");
        check("R9 irq survives", {{(DW-1){1'b0}}, irq}, 8'd1);
        step(4'b0000, 0, 1, 2'd1, "R8");
        check("R8 flag kept", rd_data, 8'h01);

        // R9: alarm change coincident with read
        step(4'b1001, 0, 1, 2'd0, "R9");
        check("R9 irq alarm", {{(DW-1){1'b0}}, irq}, 8'd1);
        step(4'b1001, 0, 1, 2'd0, "R2");
        check("R2 read 1001", rd_data, 8'h09);

        // mid-run reset
        step(4'b1111, 1, 0, 2'd0, "R1");
        do_reset();
        check("R1 irq reset", {{(DW-1){1'b0}}, irq}, 8'd0);
        check("R1 data reset", rd_data, 8'h00);

        // constrained random
        lvl = '0;
        for (int k = 0; k < 4000; k++) begin
            if ($urandom_range(7) == 0) lvl[$urandom_range(N-1)] ^= 1'b1;
            step(lvl, ($urandom_range(15) == 0), ($urandom_range(3) == 0),
                 2'($urandom_range(3)), "R2");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1000000;
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule